// File: doc/BRIEF.md
# Configuration Bit Readback Controller

This block sits beside the program-memory load path of a small CPU. It lets software read the device's lock bits and its two fuse bytes through an ordinary load instruction. Software first writes the self-programming control register with two bits set: a self-program enable bit and a read-configuration bit. That arms a short window. A program-memory load that lands inside the window returns a configuration byte, chosen by the 16-bit address pointer, in place of the flash word.

The window closes by itself. It closes when a configuration read is served, when a store strobe arrives, when the window runs out, or when the EEPROM is busy. While an EEPROM write is in progress the block refuses to arm, so no configuration read can happen. Outside the window every load passes the flash data straight through. The flash array and the CPU core are outside this block.

Each load is registered. Its result appears on `rd_data` one clock after the edge that samples `ld_strobe`. `cfg_sel` marks, for that same cycle, whether the value came from the configuration bytes.

Top module: `cfgrb_ctrl`

## Requirements
- R1: After reset `rd_data` is 0x00, `cfg_sel` is 0 and the block is disarmed, so a first load returns flash data.
- R2: A control write arms the block only when bit 0 (self-program enable) and bit 3 (read configuration) of `ctl_wr_data` are both 1. Any other value disarms it.
- R3: A load sampled on the first, second or third clock edge after the arming write returns a configuration byte. The result appears on `rd_data` one cycle after the load edge, with `cfg_sel` = 1 for that cycle.
- R4: While armed, the pointer selects the byte. 0x0000 gives the fuse low byte, 0x0001 gives the lock byte, 0x0003 gives the fuse high byte, and any other pointer value gives 0xFF.
- R5: The lock byte carries `lock_bits[1:0]` in bits 1:0 and reads 1 in bits 7:2. All configuration inputs are passed unchanged, where 0 means programmed and 1 means unprogrammed.
- R6: A served configuration read disarms the block, so the next load returns flash data.
- R7: With no load by the third edge after arming, the block disarms. A load on the fourth edge returns flash data with `cfg_sel` = 0.
- R8: A store strobe sampled while the block is armed disarms it, and a later load returns flash data.
- R9: With `ee_busy` high, a control write is ignored and leaves the block disarmed. `ee_busy` high at any edge while armed disarms the block. A load sampled together with `ee_busy` returns flash data.
- R10: A load sampled while the block is disarmed returns `flash_rdata` with `cfg_sel` = 0.
- R11: On a cycle with no load, `cfg_sel` is 0 and `rd_data` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 8 | Control register write value (bit 0 self-program enable, bit 3 read configuration) |
| ld_strobe | input | 1 | Program-memory load strobe |
| st_strobe | input | 1 | Program-memory store strobe |
| zptr | input | 16 | Address pointer |
| ee_busy | input | 1 | EEPROM write in progress |
| fuse_lo | input | 8 | Fuse low byte (0 = programmed) |
| fuse_hi | input | 8 | Fuse high byte (0 = programmed) |
| lock_bits | input | 2 | Lock bits (0 = programmed) |
| flash_rdata | input | 8 | Flash read data for the current load |
| rd_data | output | 8 | Load result |
| cfg_sel | output | 1 | High for one cycle when `rd_data` came from the configuration bytes |

## Verification
Two events can land on the same clock edge:
- the window's expiry and a load on its last allowed edge;
- an EEPROM busy assertion and a load.

The bench provokes the first by sweeping the load delay from one to five edges after arming. It expects a configuration byte up to and including the third edge and flash data from the fourth edge on. It provokes the second by raising `ee_busy` on the same edge as an armed load, and expects flash data with `cfg_sel` low. A store strobe on the first armed edge is a further collision, judged by the flash result of the load that follows.

// File: rtl/cfgrb_pkg.sv
// Package: shared constants for the configuration readback controller.
// Assumes the control register is 8 bits wide. Bit positions are fixed
// here because software relies on them.
package cfgrb_pkg;
    localparam int CTL_W       = 8;
    localparam int SPM_EN_BIT  = 0;   // self-program enable
    localparam int RDCFG_BIT   = 3;   // read configuration request

    // Which configuration byte the pointer picks
    typedef enum logic [1:0] {
        SRC_FUSE_LO = 2'd0,
        SRC_LOCK    = 2'd1,
        SRC_FUSE_HI = 2'd2,
        SRC_NONE    = 2'd3
    } cfg_src_e;
endpackage

// File: rtl/cfgrb_window.sv
// Arming window: holds the armed state and counts the cycles since the
// arming write. Assumes at most one control write per cycle. A write
// takes precedence over every clearing cause in the same cycle.
module cfgrb_window
    import cfgrb_pkg::*;
#(
    parameter int WIN_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             ld_strobe,
    input  logic             st_strobe,
    input  logic             ee_busy,
    output logic             armed
);
    localparam int CNT_W = $clog2(WIN_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYC - 1);

    logic             arm_req;
    logic [CNT_W-1:0] cnt_q;

    // Decode an arming request from the written value
    always_comb arm_req = wr_data[SPM_EN_BIT] && wr_data[RDCFG_BIT];

    // Armed flag and window counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt_q <= '0;
        end else if (wr_en) begin
            armed <= arm_req && !ee_busy;
            cnt_q <= '0;
        end else if (armed) begin
            if (ee_busy || ld_strobe || st_strobe || cnt_q == LAST) begin
                armed <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R7
    win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (cnt_q < CNT_W'(WIN_CYC)));
    // R7
    win_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && cnt_q == LAST && !wr_en) |=> !armed);
    // R6
    served_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ld_strobe && !wr_en) |=> !armed);
    // R8
    store_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && st_strobe && !wr_en) |=> !armed);
    // R9
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ee_busy) |=> !armed);
endmodule

// File: rtl/cfgrb_mux.sv
// Configuration byte selector: decodes the pointer and assembles the
// chosen byte. Purely combinational. Assumes the lock bits fill the low
// positions of the lock byte and that every unused bit reads as
// unprogrammed (1).
module cfgrb_mux
    import cfgrb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 16,
    parameter int LOCK_W = 2
) (
    input  logic [PTR_W-1:0]  zptr,
    input  logic [DATA_W-1:0] fuse_lo,
    input  logic [DATA_W-1:0] fuse_hi,
    input  logic [LOCK_W-1:0] lock_bits,
    output logic [DATA_W-1:0] cfg_byte
);
    logic [DATA_W-1:0] lock_byte;
    cfg_src_e          src;

    // Place the lock bits and pad the upper positions with ones
    for (genvar i = 0; i < DATA_W; i++) begin : g_lock
        if (i < LOCK_W) begin : g_bit
            assign lock_byte[i] = lock_bits[i];
        end else begin : g_pad
            assign lock_byte[i] = 1'b1;
        end
    end

    // Pointer decode
    always_comb begin
        if (zptr == PTR_W'(0))      src = SRC_FUSE_LO;
        else if (zptr == PTR_W'(1)) src = SRC_LOCK;
        else if (zptr == PTR_W'(3)) src = SRC_FUSE_HI;
        else                        src = SRC_NONE;
    end

    // Byte selection
    always_comb begin
        unique case (src)
            SRC_FUSE_LO: cfg_byte = fuse_lo;
            SRC_LOCK:    cfg_byte = lock_byte;
            SRC_FUSE_HI: cfg_byte = fuse_hi;
            default:     cfg_byte = {DATA_W{1'b1}};
        endcase
    end
endmodule

// File: rtl/cfgrb_ctrl.sv
// Top: configuration readback controller. Routes a program-memory load
// to a configuration byte while the arming window is open, and to flash
// data otherwise. Assumes flash_rdata is valid in the cycle ld_strobe is
// high. The result is registered and appears one cycle after the load.
module cfgrb_ctrl
    import cfgrb_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int PTR_W   = 16,
    parameter int LOCK_W  = 2,
    parameter int WIN_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_en,
    input  logic [CTL_W-1:0]  ctl_wr_data,
    input  logic              ld_strobe,
    input  logic              st_strobe,
    input  logic [PTR_W-1:0]  zptr,
    input  logic              ee_busy,
    input  logic [DATA_W-1:0] fuse_lo,
    input  logic [DATA_W-1:0] fuse_hi,
    input  logic [LOCK_W-1:0] lock_bits,
    input  logic [DATA_W-1:0] flash_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              cfg_sel
);
    logic              armed;
    logic              serve;
    logic [DATA_W-1:0] cfg_byte;

    cfgrb_window #(.WIN_CYC(WIN_CYC)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ctl_wr_en),
        .wr_data   (ctl_wr_data),
        .ld_strobe (ld_strobe),
        .st_strobe (st_strobe),
        .ee_busy   (ee_busy),
        .armed     (armed)
    );

    cfgrb_mux #(.DATA_W(DATA_W), .PTR_W(PTR_W), .LOCK_W(LOCK_W)) u_mux (
        .zptr      (zptr),
        .fuse_lo   (fuse_lo),
        .fuse_hi   (fuse_hi),
        .lock_bits (lock_bits),
        .cfg_byte  (cfg_byte)
    );

    // A load is served from configuration when armed and the EEPROM is idle
    always_comb serve = ld_strobe && armed && !ee_busy;

    // Register the load result and the source flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            cfg_sel <= 1'b0;
        end else begin
            cfg_sel <= serve;
            if (ld_strobe) rd_data <= serve ? cfg_byte : flash_rdata;
        end
    end

    // R9
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_busy |=> !cfg_sel);
    // R11
    sel_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sel |-> $past(ld_strobe));
    // R10
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_strobe && !armed) |=> (!cfg_sel && rd_data == $past(flash_rdata)));
    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_strobe |=> $stable(rd_data));
endmodule

// File: tb/tb_cfgrb_ctrl.sv
module tb_cfgrb_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic [7:0]  ctl_wr_data = '0;
    logic        ld_strobe = 1'b0;
    logic        st_strobe = 1'b0;
    logic [15:0] zptr = '0;
    logic        ee_busy = 1'b0;
    logic [7:0]  fuse_lo = 8'h62;
    logic [7:0]  fuse_hi = 8'hDF;
    logic [1:0]  lock_bits = 2'b11;
    logic [7:0]  flash_rdata = 8'h5A;
    logic [7:0]  rd_data;
    logic        cfg_sel;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cfgrb_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .ld_strobe(ld_strobe), .st_strobe(st_strobe), .zptr(zptr), .ee_busy(ee_busy),
        .fuse_lo(fuse_lo), .fuse_hi(fuse_hi), .lock_bits(lock_bits),
        .flash_rdata(flash_rdata), .rd_data(rd_data), .cfg_sel(cfg_sel)
    );

    function automatic logic [7:0] exp_cfg(input logic [15:0] p);
        if (p == 16'h0000) return fuse_lo;
        if (p == 16'h0001) return {6'b111111, lock_bits};
        if (p == 16'h0003) return fuse_hi;
        return 8'hFF;
    endfunction

    task automatic chk(input string tag, input logic [7:0] ed, input logic es);
        n_run++;
        if (rd_data !== ed || cfg_sel !== es) begin
            n_fail++;
            $display("FAIL %s: got data=%h sel=%b, expected data=%h sel=%b",
                     tag, rd_data, cfg_sel, ed, es);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Control write; returns at the negedge after the write edge
    task automatic wr(input logic [7:0] d);
        ctl_wr_en = 1'b1; ctl_wr_data = d;
        @(negedge clk);
        ctl_wr_en = 1'b0; ctl_wr_data = '0;
    endtask

    // Load; the result is visible at return
    task automatic ld(input logic [15:0] p, input logic [7:0] f);
        ld_strobe = 1'b1; zptr = p; flash_rdata = f;
        @(negedge clk);
        ld_strobe = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] ptrs [10];
        ptrs = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h0004,
                 16'h0007, 16'h0100, 16'h8001, 16'hFFFF, 16'h0103};
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 reset", 8'h00, 1'b0);
        ld(16'h0000, 8'hA5);
        chk("R1 first load", 8'hA5, 1'b0);

        // R2: every control value, load on the first edge
        for (int d = 0; d < 256; d++) begin
            logic [7:0] dv;
            logic       arm;
            dv = 8'(d);
            arm = dv[0] && dv[3];
            wr(dv);
            ld(16'h0000, 8'h5A);
            chk("R2 arm decode", arm ? fuse_lo : 8'h5A, arm);
        end

        // R3 / R7: load delay sweep (edges after arming)
        for (int dl = 1; dl <= 5; dl++) begin
            wr(8'h09);
            idle(dl - 1);
            ld(16'h0003, 8'h3C);
            if (dl <= 3) chk("R3 load in window", fuse_hi, 1'b1);
            else         chk("R7 load after expiry", 8'h3C, 1'b0);
        end

        // R4 / R5: pointer sweep with varied configuration values
        for (int lv = 0; lv < 4; lv++) begin
            for (int pi = 0; pi < 10; pi++) begin
                lock_bits = 2'(lv);
                fuse_lo = 8'(8'h11 * lv + pi);
                fuse_hi = 8'(8'hC3 ^ (lv << 4) ^ pi);
                wr(8'h09);
                ld(ptrs[pi], 8'h5A);
                chk("R4 R5 pointer decode", exp_cfg(ptrs[pi]), 1'b1);
            end
        end

        // R6: served read disarms
        wr(8'h09);
        ld(16'h0001, 8'h5A);
        chk("R6 served", exp_cfg(16'h0001), 1'b1);
        ld(16'h0001, 8'h77);
        chk("R6 second load", 8'h77, 1'b0);

        // R8: store strobe on the first armed edge
        wr(8'h09);
        st_strobe = 1'b1; @(negedge clk); st_strobe = 1'b0;
        ld(16'h0000, 8'h4B);
        chk("R8 store clears", 8'h4B, 1'b0);

        // R9: write while busy is ignored
        ee_busy = 1'b1;
        wr(8'h09);
        ee_busy = 1'b0;
        ld(16'h0000, 8'h2D);
        chk("R9 busy write", 8'h2D, 1'b0);
        // R9: busy while armed, load later
        wr(8'h09);
        ee_busy = 1'b1; @(negedge clk); ee_busy = 1'b0;
        ld(16'h0000, 8'h1E);
        chk("R9 busy disarm", 8'h1E, 1'b0);
        // R9: busy on the same edge as the load
        wr(8'h09);
        ee_busy = 1'b1;
        ld(16'h0000, 8'h0F);
        ee_busy = 1'b0;
        chk("R9 busy with load", 8'h0F, 1'b0);

        // R10: pass-through sweep while disarmed
        for (int v = 0; v < 16; v++) begin
            ld(16'(v), 8'(v * 17 + 3));
            chk("R10 passthrough", 8'(v * 17 + 3), 1'b0);
        end

        // R11: no load holds data, flag low
        wr(8'h09);
        ld(16'h0003, 8'h5A);
        idle(1);
        chk("R11 hold", fuse_hi, 1'b0);
        idle(3);
        chk("R11 hold later", fuse_hi, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule